// File: doc/BRIEF.md
# Sequenced 8x8 Multiplier with Signed Correction

This block multiplies two 8-bit operands and stores the 16-bit result in a pair of product registers: an upper byte and a lower byte. In unsigned mode the product is written on the clock edge that accepts the start strobe. In signed mode the same unsigned product is written first. A short fixed sequence then tests each operand's top bit and, where that bit is set, subtracts the other operand from the upper product byte. The result is the two's-complement product.

The operands are captured when a start is accepted, so the caller may change the inputs freely while a signed sequence runs. A one-cycle done pulse marks the point where the product registers hold their final value. The block has no status flag outputs.

Top module: `mul8_seq`

## Requirements
- R1: After reset, prod_hi and prod_lo are 0, and busy and done are 0.
- R2: In unsigned mode (signed_mode = 0), an accepted start loads {prod_hi, prod_lo} with the unsigned 16-bit product of op_a and op_b on the accepting edge. done is 1 for the following cycle and busy stays 0.
- R3: signed_mode is sampled only when a start is accepted: 0 selects the unsigned product and 1 selects the signed sequence.
- R4: In signed mode, the final value of prod_hi is the unsigned high byte, minus op_a if op_b[7] is 1, minus op_b if op_a[7] is 1, all modulo 256. This makes {prod_hi, prod_lo} the two's-complement product.
- R5: A signed operation takes six clock edges, counting the accepting edge. busy is 1 after the accepting edge and through the next four edges. After the sixth edge busy is 0 and done is 1.
- R6: A start that arrives while busy is 1 is ignored: it does not restart the sequence, lengthen it or change the result.
- R7: The operands and mode are latched on the accepting edge. Changes on op_a, op_b or signed_mode during a signed sequence do not affect its result.
- R8: done is high for exactly one cycle per operation and is never high while busy is high.
- R9: When no start is accepted and no sequence is running, prod_hi and prod_lo keep their value.
- R10: The correction steps never change prod_lo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a multiply |
| signed_mode | input | 1 | 0 = unsigned, 1 = signed |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| prod_hi | output | 8 | Upper product byte |
| prod_lo | output | 8 | Lower product byte |
| busy | output | 1 | Signed sequence in progress |
| done | output | 1 | One-cycle pulse when the product is final |

## Verification
An unsigned result and its done pulse are due one edge after the strobe. A signed result is due six edges after the strobe; the first edge already shows the uncorrected product and the low byte. Each task drives its inputs just after a rising edge and counts rising edges explicitly before it samples. During the four middle edges of a signed run it checks busy, the absence of done and a frozen low byte. One edge after done it checks that done has fallen and the product has held.

// File: rtl/mul8_seq.sv
module mul8_seq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo,
  output logic         busy,
  output logic         done
);

  localparam int SW        = 3;
  localparam int MSB       = W - 1;
  localparam logic [SW-1:0] STEP_SUB_A = SW'(2);
  localparam logic [SW-1:0] STEP_SUB_B = SW'(4);
  localparam logic [SW-1:0] STEP_LAST  = SW'(5);

  logic [W-1:0]   a_q, b_q;
  logic [SW-1:0]  step;
  logic [2*W-1:0] raw_prod;
  logic           take;

  assign take     = start && !busy;
  assign raw_prod = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      prod_hi <= '0;
      prod_lo <= '0;
      step    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        a_q                <= op_a;
        b_q                <= op_b;
        {prod_hi, prod_lo} <= raw_prod;
        if (signed_mode) begin
          busy <= 1'b1;
          step <= SW'(1);
        end else begin
          done <= 1'b1;
        end
      end else if (busy) begin
        step <= step + SW'(1);
        if (step == STEP_SUB_A && b_q[MSB]) prod_hi <= prod_hi - a_q;
        if (step == STEP_SUB_B && a_q[MSB]) prod_hi <= prod_hi - b_q;
        if (step == STEP_LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          step <= '0;
        end
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (prod_hi == '0 && prod_lo == '0 && !busy && !done)); // R1
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !(done && busy)); // R8
  AST_LO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(prod_lo)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo))); // R9
  AST_BUSY_ONLY_SIGNED: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start && signed_mode)); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> (busy || done)); // R6
  AST_END_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R5

endmodule

// File: tb/tb_mul8_seq.sv
module tb_mul8_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       signed_mode = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic [7:0] prod_hi, prod_lo;
  logic       busy, done;
  int checks = 0;
  int fails  = 0;

  mul8_seq dut (.clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
                .op_a(op_a), .op_b(op_b), .prod_hi(prod_hi), .prod_lo(prod_lo),
                .busy(busy), .done(done));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; edge1(); edge1(); rst_n = 1'b1;
    check({prod_hi, prod_lo} == 16'h0, "R1 product", {prod_hi, prod_lo}, 16'h0);
    check({busy, done} == 2'b00, "R1 busy/done", {14'h0, busy, done}, 16'h0);
  endtask

  task automatic t_unsigned(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] exp = 16'(a) * 16'(b);
    start = 1'b1; signed_mode = 1'b0; op_a = a; op_b = b;
    edge1(); start = 1'b0;
    check({prod_hi, prod_lo} == exp, "R2 unsigned product", {prod_hi, prod_lo}, exp);
    check(done && !busy, "R2 done after one edge", {14'h0, busy, done}, 16'h1);
    op_a = ~a; op_b = ~b;
    edge1();
    check(!done, "R8 done one cycle", {15'h0, done}, 16'h0);
    check({prod_hi, prod_lo} == exp, "R9 hold", {prod_hi, prod_lo}, exp);
  endtask

  task automatic t_signed(input logic [7:0] a, input logic [7:0] b, input bit disturb);
    logic [15:0] exp  = 16'($signed(a) * $signed(b));
    logic [15:0] uexp = 16'(a) * 16'(b);
    start = 1'b1; signed_mode = 1'b1; op_a = a; op_b = b;
    edge1(); start = 1'b0;
    check(busy && !done, "R5 busy after accept", {14'h0, busy, done}, 16'h2);
    check(prod_lo == uexp[7:0], "R10 low byte", {8'h0, prod_lo}, {8'h0, uexp[7:0]});
    for (int i = 0; i < 4; i++) begin
      if (disturb) begin
        op_a = 8'(a + 8'(i) + 8'd37); op_b = ~b; signed_mode = i[0]; start = 1'b1;
      end
      edge1();
      check(busy && !done, disturb ? "R6 start ignored mid run" : "R5 busy mid run", {14'h0, busy, done}, 16'h2);
      check(prod_lo == uexp[7:0], "R10 low byte frozen", {8'h0, prod_lo}, {8'h0, uexp[7:0]});
    end
    start = 1'b0;
    edge1();
    check(done && !busy, "R5 done on sixth edge", {14'h0, busy, done}, 16'h1);
    check({prod_hi, prod_lo} == exp, disturb ? "R7 latched operands" : "R4 signed product", {prod_hi, prod_lo}, exp);
    edge1();
    check(!done && !busy, "R8 single done pulse", {14'h0, busy, done}, 16'h0);
    check({prod_hi, prod_lo} == exp, "R9 hold after signed", {prod_hi, prod_lo}, exp);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual %h expected %h", 16'h1, 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_unsigned(8'hFF, 8'hFF);
    t_unsigned(8'h03, 8'h05);
    t_unsigned(8'h00, 8'hA7);
    t_signed(8'hFF, 8'hFF, 1'b0);
    t_signed(8'h80, 8'h80, 1'b0);
    t_signed(8'h80, 8'h7F, 1'b0);
    t_signed(8'h05, 8'hFD, 1'b0);
    t_signed(8'hF9, 8'h06, 1'b0);
    t_signed(8'h7F, 8'h7F, 1'b0);
    t_signed(8'h9C, 8'hE3, 1'b1);
    t_unsigned(8'h80, 8'h02);  // R3: mode 0 after a signed run gives the unsigned result
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule